// File: doc/BRIEF.md
# FIFO Occupancy Tracker with Threshold Interrupts

This block keeps the fill level of a UART's transmit FIFO and receive FIFO, each holding up to 64 characters. It watches the push and pop strobes of each FIFO and presents the current level as an 8-bit value. It also holds one 8-bit trigger value for each direction, which the host can write but cannot read back. From each level and its trigger it derives a level-sensitive interrupt.

The two interrupts use opposite rules. The transmit interrupt means "room to refill": it is high while the transmit level is strictly below its trigger. The receive interrupt means "data to drain": it is high once the receive level has risen to its trigger or above. Neither interrupt is latched. Each one drops as soon as its condition stops holding.

Each direction's level is tracked by a three-state machine:

- States: `LVL_EMPTY` (level 0), `LVL_PART` (level 1 to 63) and `LVL_FULL` (level 64).
- Transitions, with "push" meaning a push without a pop and "pop" meaning a pop without a push:
  - `LVL_EMPTY`→`LVL_PART` on a push.
  - `LVL_PART`→`LVL_FULL` on a push at level 63.
  - `LVL_PART`→`LVL_EMPTY` on a pop at level 1.
  - `LVL_FULL`→`LVL_PART` on a pop.
- Every other case keeps the current state, including a push and a pop together.
- A push in `LVL_FULL` or a pop in `LVL_EMPTY` is illegal. It is ignored and flagged.

Top module: `fifo_level_irq`

## Requirements
- R1: After reset both levels are 0, both triggers are 0, both error flags are 0, `tx_irq` is 0 and `rx_irq` is 1.
- R2: A push alone raises that FIFO's level by one and a pop alone lowers it by one. The new level is visible in the cycle after the clock edge that samples the strobe.
- R3: A push and a pop on the same FIFO in the same cycle leave its level unchanged and raise no error flag, whatever the level.
- R4: A push alone at level 64 is ignored. The level stays 64, never exceeds 64, and that FIFO's error flag is 1 for exactly the following cycle.
- R5: A pop alone at level 0 is ignored. The level stays 0, and that FIFO's error flag is 1 for exactly the following cycle.
- R6: A trigger write stores the written value, or 64 if the written value is above 64. The new trigger takes effect on the interrupt in the cycle after the write edge.
- R7: `tx_irq` is 1 exactly when `tx_level` is less than the transmit trigger. A trigger of 0 therefore never raises it.
- R8: `rx_irq` is 1 exactly when `rx_level` is greater than or equal to the receive trigger. A trigger of 0 therefore holds it high.
- R9: Strobes and trigger writes of one direction have no effect on the other direction's level, error flag or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_push | input | 1 | Character written into the transmit FIFO |
| tx_pop | input | 1 | Character taken from the transmit FIFO |
| rx_push | input | 1 | Character written into the receive FIFO |
| rx_pop | input | 1 | Character taken from the receive FIFO |
| tx_trig_we | input | 1 | Write strobe for the transmit trigger |
| tx_trig_wdata | input | 8 | Transmit trigger value to write |
| rx_trig_we | input | 1 | Write strobe for the receive trigger |
| rx_trig_wdata | input | 8 | Receive trigger value to write |
| tx_level | output | 8 | Current transmit FIFO level, 0 to 64 |
| rx_level | output | 8 | Current receive FIFO level, 0 to 64 |
| tx_err | output | 1 | One-cycle flag after an ignored transmit push or pop |
| rx_err | output | 1 | One-cycle flag after an ignored receive push or pop |
| tx_irq | output | 1 | Transmit level below its trigger |
| rx_irq | output | 1 | Receive level at or above its trigger |

## Verification
Levels and error flags are registered, so they are due one cycle after the edge that samples a strobe. The interrupts are combinational from registered levels and triggers, so they follow a strobe or a trigger write in that same cycle. The bench drives every input on the falling edge and samples 1 ns after the next rising edge. Each check therefore sees exactly the first cycle in which a result is due, and an error flag is checked again one cycle later to confirm that it is a single-cycle pulse.

// File: rtl/fifo_level_pkg.sv
package fifo_level_pkg;
    typedef enum logic [1:0] {
        LVL_EMPTY = 2'd0,
        LVL_PART  = 2'd1,
        LVL_FULL  = 2'd2
    } lvl_state_t;
endpackage

// File: rtl/lvl_track.sv
module lvl_track
    import fifo_level_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic [CW-1:0] lvl,
    output logic          err
);
    localparam logic [CW-1:0] TOP = CW'(DEPTH);
    localparam logic [CW-1:0] ONE = CW'(1);

    lvl_state_t    state, nxt_state;
    logic [CW-1:0] nxt_lvl;
    logic          ill;
    logic          inc, dec;

    assign inc = push && !pop;
    assign dec = pop && !push;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LVL_EMPTY;
            lvl   <= '0;
            err   <= 1'b0;
        end else begin
            state <= nxt_state;
            lvl   <= nxt_lvl;
            err   <= ill;
        end
    end

    // next state and outputs
    always_comb begin
        nxt_state = state;
        nxt_lvl   = lvl;
        ill       = 1'b0;
        unique case (state)
            LVL_EMPTY: begin
                if (inc) begin
                    nxt_lvl   = lvl + ONE;
                    nxt_state = (DEPTH == 1) ? LVL_FULL : LVL_PART;
                end else if (dec) begin
                    ill = 1'b1;
                end
            end
            LVL_PART: begin
                if (inc) begin
                    nxt_lvl = lvl + ONE;
                    if (lvl == TOP - ONE) nxt_state = LVL_FULL;
                end else if (dec) begin
                    nxt_lvl = lvl - ONE;
                    if (lvl == ONE) nxt_state = LVL_EMPTY;
                end
            end
            LVL_FULL: begin
                if (dec) begin
                    nxt_lvl   = lvl - ONE;
                    nxt_state = (DEPTH == 1) ? LVL_EMPTY : LVL_PART;
                end else if (inc) begin
                    ill = 1'b1;
                end
            end
            default: begin
                nxt_state = LVL_EMPTY;
                nxt_lvl   = '0;
            end
        endcase
    end

    assert_level_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lvl <= TOP);

    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push ^ pop |=> (lvl == $past(lvl)) || (lvl == $past(lvl) + ONE) || (lvl == $past(lvl) - ONE));

    assert_push_pop_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push && pop |=> $stable(lvl) && !err);

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop && lvl == TOP |=> err && lvl == TOP);

    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !push && lvl == '0 |=> err && lvl == '0);
endmodule

// File: rtl/trig_reg.sv
module trig_reg #(
    parameter int MAXV = 64,
    parameter int W    = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] trig
);
    localparam logic [W-1:0] CAP = W'(MAXV);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   trig <= '0;
        else if (we)  trig <= (wdata > CAP) ? CAP : wdata;
    end

    assert_trig_clamped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        we && wdata > CAP |=> trig == CAP);
endmodule

// File: rtl/lvl_cmp.sv
module lvl_cmp #(
    parameter int  W     = 8,
    parameter bit  BELOW = 1'b1
) (
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] trig,
    output logic         irq
);
    generate
        if (BELOW) begin : g_below
            assign irq = lvl < trig;
        end else begin : g_reach
            assign irq = lvl >= trig;
        end
    endgenerate
endmodule

// File: rtl/fifo_level_irq.sv
module fifo_level_irq #(
    parameter int DEPTH = 64,
    parameter int CW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_push,
    input  logic          tx_pop,
    input  logic          rx_push,
    input  logic          rx_pop,
    input  logic          tx_trig_we,
    input  logic [CW-1:0] tx_trig_wdata,
    input  logic          rx_trig_we,
    input  logic [CW-1:0] rx_trig_wdata,
    output logic [CW-1:0] tx_level,
    output logic [CW-1:0] rx_level,
    output logic          tx_err,
    output logic          rx_err,
    output logic          tx_irq,
    output logic          rx_irq
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] tx_trig, rx_trig;

    lvl_track #(.DEPTH(DEPTH), .CW(CW)) u_tx_track (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop),
        .lvl(tx_level), .err(tx_err)
    );

    lvl_track #(.DEPTH(DEPTH), .CW(CW)) u_rx_track (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop),
        .lvl(rx_level), .err(rx_err)
    );

    trig_reg #(.MAXV(DEPTH), .W(CW)) u_tx_trig (
        .clk(clk), .rst_n(rst_n), .we(tx_trig_we), .wdata(tx_trig_wdata),
        .trig(tx_trig)
    );

    trig_reg #(.MAXV(DEPTH), .W(CW)) u_rx_trig (
        .clk(clk), .rst_n(rst_n), .we(rx_trig_we), .wdata(rx_trig_wdata),
        .trig(rx_trig)
    );

    lvl_cmp #(.W(CW), .BELOW(1'b1)) u_tx_cmp (
        .lvl(tx_level), .trig(tx_trig), .irq(tx_irq)
    );

    lvl_cmp #(.W(CW), .BELOW(1'b0)) u_rx_cmp (
        .lvl(rx_level), .trig(rx_trig), .irq(rx_irq)
    );

    // with a steady trigger the level moves by one, so a rise is an exact crossing
    assert_tx_irq_cross_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_irq) && $stable(tx_trig) |-> tx_level == tx_trig - ONE);

    assert_rx_irq_cross_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) && $stable(rx_trig) |-> rx_level == rx_trig);
endmodule

// File: tb/fifo_level_irq_tb.sv
module fifo_level_irq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
    logic       tx_trig_we = 0, rx_trig_we = 0;
    logic [7:0] tx_trig_wdata = 0, rx_trig_wdata = 0;
    logic [7:0] tx_level, rx_level;
    logic       tx_err, rx_err, tx_irq, rx_irq;

    int runs = 0;
    int fails = 0;
    int mtx = 0;
    int mrx = 0;

    always #5 clk = ~clk;

    fifo_level_irq u_dut (
        .clk(clk), .rst_n(rst_n),
        .tx_push(tx_push), .tx_pop(tx_pop), .rx_push(rx_push), .rx_pop(rx_pop),
        .tx_trig_we(tx_trig_we), .tx_trig_wdata(tx_trig_wdata),
        .rx_trig_we(rx_trig_we), .rx_trig_wdata(rx_trig_wdata),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_err(tx_err), .rx_err(rx_err), .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    task automatic check(string req, int act, int exp);
        runs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive strobes on the falling edge, sample 1 ns after the rising edge
    task automatic cyc(bit tp, bit to, bit rp, bit ro);
        @(negedge clk);
        tx_push = tp; tx_pop = to; rx_push = rp; rx_pop = ro;
        tx_trig_we = 0; rx_trig_we = 0;
        @(posedge clk);
        #1;
        if (tp && !to && mtx < 64) mtx++;
        if (to && !tp && mtx > 0)  mtx--;
        if (rp && !ro && mrx < 64) mrx++;
        if (ro && !rp && mrx > 0)  mrx--;
    endtask

    task automatic wr_trig(bit is_tx, logic [7:0] v);
        @(negedge clk);
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
        tx_trig_we = is_tx; rx_trig_we = !is_tx;
        tx_trig_wdata = v; rx_trig_wdata = v;
        @(posedge clk);
        #1;
        tx_trig_we = 0; rx_trig_we = 0;
    endtask

    task automatic t_reset();
        check("R1 tx_level", tx_level, 0);
        check("R1 rx_level", rx_level, 0);
        check("R1 tx_err", tx_err, 0);
        check("R1 rx_err", rx_err, 0);
        check("R1 tx_irq", tx_irq, 0);
        check("R1 rx_irq", rx_irq, 1);
    endtask

    task automatic t_step();
        cyc(1, 0, 0, 0);
        check("R2 tx push", tx_level, 1);
        check("R9 rx untouched by tx", rx_level, 0);
        cyc(1, 0, 1, 0);
        check("R2 tx push 2", tx_level, 2);
        check("R2 rx push", rx_level, 1);
        cyc(0, 1, 0, 0);
        check("R2 tx pop", tx_level, 1);
        check("R9 rx held", rx_level, 1);
    endtask

    task automatic t_simul();
        cyc(1, 1, 1, 1);
        check("R3 tx hold", tx_level, mtx);
        check("R3 rx hold", rx_level, mrx);
        check("R3 no tx err", tx_err, 0);
        while (mrx > 0) cyc(0, 0, 0, 1);
        cyc(0, 0, 1, 1);
        check("R3 hold at empty", rx_level, 0);
        check("R3 no err at empty", rx_err, 0);
    endtask

    task automatic t_underflow();
        while (mtx > 0) cyc(0, 1, 0, 0);
        cyc(0, 1, 0, 0);
        check("R5 level stays 0", tx_level, 0);
        check("R5 tx_err pulse", tx_err, 1);
        check("R9 rx_err quiet", rx_err, 0);
        cyc(0, 0, 0, 0);
        check("R5 tx_err one cycle", tx_err, 0);
    endtask

    task automatic t_overflow();
        while (mrx < 64) cyc(0, 0, 1, 0);
        check("R4 rx full", rx_level, 64);
        cyc(0, 0, 1, 0);
        check("R4 level stays 64", rx_level, 64);
        check("R4 rx_err pulse", rx_err, 1);
        cyc(0, 0, 0, 0);
        check("R4 rx_err one cycle", rx_err, 0);
        cyc(0, 0, 1, 1);
        check("R3 hold at full", rx_level, 64);
        check("R3 no err at full", rx_err, 0);
        while (mrx > 0) cyc(0, 0, 0, 1);
    endtask

    task automatic t_tx_irq();
        wr_trig(1, 8'd3);
        check("R6 R7 tx_irq after trig write", tx_irq, 1);
        check("R9 rx_irq unchanged", rx_irq, 1);
        cyc(1, 0, 0, 0);
        cyc(1, 0, 0, 0);
        check("R7 level 2 below 3", tx_irq, 1);
        cyc(1, 0, 0, 0);
        check("R7 level 3 not below 3", tx_irq, 0);
        cyc(0, 1, 0, 0);
        check("R7 back below", tx_irq, 1);
        wr_trig(1, 8'd0);
        check("R7 trig 0 never", tx_irq, 0);
        while (mtx > 0) cyc(0, 1, 0, 0);
        check("R7 trig 0 at empty", tx_irq, 0);
    endtask

    task automatic t_rx_irq();
        wr_trig(0, 8'd2);
        check("R6 R8 rx_irq after trig write", rx_irq, 0);
        check("R9 tx_irq unchanged", tx_irq, 0);
        cyc(0, 0, 1, 0);
        check("R8 level 1 below 2", rx_irq, 0);
        cyc(0, 0, 1, 0);
        check("R8 level reaches 2", rx_irq, 1);
        cyc(0, 0, 1, 0);
        check("R8 level above 2", rx_irq, 1);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 1);
        check("R8 clears below", rx_irq, 0);
        while (mrx > 0) cyc(0, 0, 0, 1);
    endtask

    task automatic t_clamp();
        wr_trig(0, 8'hFF);
        while (mrx < 63) cyc(0, 0, 1, 0);
        check("R6 rx clamp level 63", rx_irq, 0);
        cyc(0, 0, 1, 0);
        check("R6 rx clamp level 64", rx_irq, 1);
        wr_trig(1, 8'h41);
        while (mtx < 64) cyc(1, 0, 0, 0);
        check("R6 tx clamp level 64", tx_irq, 0);
        cyc(0, 1, 0, 0);
        check("R6 tx clamp level 63", tx_irq, 1);
    endtask

    initial begin
        #1;
        repeat (2) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset();
        t_step();
        t_simul();
        t_underflow();
        t_overflow();
        t_tx_irq();
        t_rx_irq();
        t_clamp();
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin
        #200000;
        runs++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule